// File: doc/BRIEF.md
# UART FIFO and interrupt controller

This block holds the byte queues and the interrupt logic of a 16550-compatible serial port. The serial engine outside it does the bit timing. A receive queue takes bytes from an external deserializer and the host reads them. A transmit queue takes bytes from the host and hands them one at a time to an external serializer over a valid/ready handshake. The host reaches three configuration registers through a single strobed write port: queue control, interrupt enable and modem control. It reads the interrupt identification byte and the line status byte combinationally. Each of those two bytes has its own read strobe for the side effects of a read.

The transmit hand-off is driven by a three-state machine:
- `TX_IDLE` moves to `TX_OFFER` when the queue holds a byte and the clear-to-send gate is open. It moves to `TX_HOLD` when a byte is waiting but the gate is shut.
- `TX_HOLD` moves to `TX_OFFER` once the gate opens. It returns to `TX_IDLE` on a flush.
- `TX_OFFER` drives the head byte and returns to `TX_IDLE` when the serializer accepts it or when the queue is flushed.

When automatic request-to-send is enabled, the block withholds permission from the far end while the receive queue sits at or above its trigger level.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset the line status reads 0x60, the identification byte reads 0x01, `irq` is 0, `rts_n` is 1 and `ser_valid` is 0.
- R2: Each queue holds 16 bytes. Bytes leave each queue in the order they entered.
- R3: A deserializer byte that arrives at a full receive queue is dropped and sets line status bit 1 (overrun). A byte flagged with a framing error is stored and sets bit 3. A line status read clears both flags. A host write to a full transmit queue is dropped.
- R4: A host read of an empty receive queue leaves `host_rx_data` at the last byte read (0 after reset).
- R5: Configuration select 0 writes queue control. Bit 0 enables the queues; when it is 0 each queue holds one byte. Bit 1 flushes the receive queue and bit 2 flushes the transmit queue, and neither bit is stored. Any change of bit 0 flushes both queues.
- R6: Queue control bits 7:6 pick the receive trigger: 0→1, 1→4, 2→8, 3→14 bytes. The trigger is 1 while the queues are disabled. With interrupt enable bit 0 set, receive data available is reported once the count reaches the trigger.
- R7: The identification byte carries the source in bits 3:1: 3 for line status, 2 for receive data and 1 for transmit empty, in that priority order. Bit 0 is 1 when nothing is pending, and bits 7:6 both copy the queue enable. `irq` is high exactly when a source is reported. Interrupt enable is configuration select 1: bit 0 receive data, bit 1 transmit empty, bit 2 line status.
- R8: Transmit empty becomes pending when the transmit queue drains by hand-off or flush, or when enable bit 1 is set while the queue is empty. It clears on an identification read that reports it, on a host transmit write, or when enable bit 1 is cleared.
- R9: Line status bit 0 shows that the receive queue is not empty. Bit 5 shows that the transmit queue is empty. Bit 6 is set only when the transmit queue is empty, `ser_busy` is low and no byte is being offered.
- R10: Modem control is configuration select 2. With bit 6 set, `rts_n` is 1 while the receive count is at or above the trigger and 0 otherwise. With bit 6 clear, `rts_n` is the inverse of bit 1.
- R11: With modem control bit 7 set, a high `cts_n` keeps the next byte from being offered. A byte already offered stays offered.
- R12: While `ser_valid` is high and `ser_ready` is low, `ser_valid` and `ser_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 queue control, 1 interrupt enable, 2 modem control |
| cfg_data | input | 8 | Configuration write data |
| host_tx_wr | input | 1 | Push one byte into the transmit queue |
| host_tx_data | input | 8 | Byte to transmit |
| host_rx_rd | input | 1 | Pop one byte from the receive queue |
| host_rx_data | output | 8 | Last byte popped from the receive queue |
| id_rd | input | 1 | Identification read strobe |
| id_val | output | 8 | Interrupt identification byte |
| ls_rd | input | 1 | Line status read strobe |
| ls_val | output | 8 | Line status byte |
| dsr_valid | input | 1 | Deserializer byte strobe |
| dsr_data | input | 8 | Received byte |
| dsr_frame_err | input | 1 | Framing error on the received byte |
| ser_valid | output | 1 | Byte offered to the serializer |
| ser_data | output | 8 | Offered byte |
| ser_ready | input | 1 | Serializer accepts the offered byte |
| ser_busy | input | 1 | Serializer shift register still sending |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, queue pushes, pops and status reads all take effect at the next rising edge. The status byte, the identification byte, `rts_n` and `irq` are combinational from registers, so each one is due just after the edge that follows its stimulus. A byte written into an empty transmit queue appears on `ser_valid` after two edges: one stores the byte and one moves the machine out of `TX_IDLE`. Once the auto clear-to-send gate opens, `TX_HOLD` takes one edge to reach `TX_OFFER`. The bench drives every input one nanosecond after a rising edge and samples after the following edge, so each check lands in the cycle its result is due. It compares against a queue model and an identification function kept in the bench.

// File: rtl/ufic_pkg.sv
`timescale 1ns/1ps
package ufic_pkg;

    typedef enum logic [2:0] {
        ID_NONE = 3'd0,
        ID_THRE = 3'd1,
        ID_RDA  = 3'd2,
        ID_RLS  = 3'd3
    } irq_id_e;

    typedef enum logic [1:0] {
        SEL_FIFO  = 2'd0,
        SEL_IEN   = 2'd1,
        SEL_MODEM = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HOLD  = 2'd1,
        TX_OFFER = 2'd2
    } tx_state_e;

    // receive trigger threshold for the two-bit level code
    function automatic logic [4:0] trig_level(input logic [1:0] code);
        logic [4:0] lvl;
        unique case (code)
            2'd0: lvl = 5'd1;
            2'd1: lvl = 5'd4;
            2'd2: lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/ufic_fifo.sv
`timescale 1ns/1ps
module ufic_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign full    = (cnt_q >= cap);
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem_q[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) begin
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (pop_ok) begin
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R2: occupancy never exceeds the storage
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R3: a push into a full queue leaves the count unchanged unless a pop happens
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(cnt_q));

endmodule

// File: rtl/ufic_tx_fsm.sv
`timescale 1ns/1ps
module ufic_tx_fsm
    import ufic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic have_data,
    input  logic cts_block,
    input  logic ser_ready,
    output logic ser_valid,
    output logic pop
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (have_data && !flush) begin
                    state_d = cts_block ? TX_HOLD : TX_OFFER;
                end
            end
            TX_HOLD: begin
                if (flush || !have_data) begin
                    state_d = TX_IDLE;
                end else if (!cts_block) begin
                    state_d = TX_OFFER;
                end
            end
            TX_OFFER: begin
                if (flush || ser_ready) begin
                    state_d = TX_IDLE;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        ser_valid = (state_q == TX_OFFER);
        pop       = ser_valid && ser_ready && !flush;
    end

    // R12: an unaccepted offer stays up
    p_offer_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_ready && !flush) |=> ser_valid);

    // R11: a closed gate keeps a new offer from starting
    p_cts_holdoff_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_OFFER && cts_block) |=> (state_q != TX_OFFER));

endmodule

// File: rtl/ufic_irq.sv
`timescale 1ns/1ps
module ufic_irq
    import ufic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ien,
    input  logic       thre_en_nxt,
    input  logic       line_err,
    input  logic       rx_at_trig,
    input  logic       thre_evt,
    input  logic       wr_clr,
    input  logic       id_rd,
    output irq_id_e    id_code,
    output logic       irq
);

    logic thre_pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_pend_q <= 1'b0;
        end else if (!thre_en_nxt) begin
            thre_pend_q <= 1'b0;
        end else if (thre_evt) begin
            thre_pend_q <= 1'b1;
        end else if (wr_clr || (id_rd && id_code == ID_THRE)) begin
            thre_pend_q <= 1'b0;
        end
    end

    always_comb begin
        if (ien[2] && line_err) begin
            id_code = ID_RLS;
        end else if (ien[0] && rx_at_trig) begin
            id_code = ID_RDA;
        end else if (thre_pend_q) begin
            id_code = ID_THRE;
        end else begin
            id_code = ID_NONE;
        end
        irq = (id_code != ID_NONE);
    end

    // R7: a request is only raised with some source enabled
    p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != 3'b000));

    // R8: a host transmit write removes a transmit-empty report
    p_thre_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !thre_evt) |=> (id_code != ID_THRE));

endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module uart_fifo_irq_ctrl
    import ufic_pkg::*;
#(
    parameter int BW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [7:0]    cfg_data,
    input  logic          host_tx_wr,
    input  logic [BW-1:0] host_tx_data,
    input  logic          host_rx_rd,
    output logic [BW-1:0] host_rx_data,
    input  logic          id_rd,
    output logic [7:0]    id_val,
    input  logic          ls_rd,
    output logic [7:0]    ls_val,
    input  logic          dsr_valid,
    input  logic [BW-1:0] dsr_data,
    input  logic          dsr_frame_err,
    output logic          ser_valid,
    output logic [BW-1:0] ser_data,
    input  logic          ser_ready,
    input  logic          ser_busy,
    input  logic          cts_n,
    output logic          rts_n,
    output logic          irq
);

    localparam int CW = $clog2(DEPTH + 1);

    // configuration state
    logic       fcr_en_q;
    logic [1:0] trig_sel_q;
    logic [2:0] ier_q, ier_d;
    logic       man_rts_q, auto_rts_q, auto_cts_q;
    logic       overrun_q, frame_q;
    logic [BW-1:0] rx_last_q;

    logic fcr_wr, ier_wr, mcr_wr;
    logic rx_flush, tx_flush;
    logic [CW-1:0] cap, trig;

    logic [BW-1:0] rx_head, tx_head;
    logic [CW-1:0] rx_count, tx_count;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic tx_pop, tx_push_ok, thre_evt, line_err, rx_at_trig;
    irq_id_e id_code;

    always_comb begin
        fcr_wr   = cfg_wr && (cfg_sel == SEL_FIFO);
        ier_wr   = cfg_wr && (cfg_sel == SEL_IEN);
        mcr_wr   = cfg_wr && (cfg_sel == SEL_MODEM);
        rx_flush = fcr_wr && (cfg_data[1] || (cfg_data[0] != fcr_en_q));
        tx_flush = fcr_wr && (cfg_data[2] || (cfg_data[0] != fcr_en_q));
        ier_d    = ier_wr ? cfg_data[2:0] : ier_q;
        cap      = fcr_en_q ? CW'(DEPTH) : CW'(1);
        trig     = fcr_en_q ? CW'(trig_level(trig_sel_q)) : CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcr_en_q   <= 1'b0;
            trig_sel_q <= 2'd0;
            ier_q      <= 3'd0;
            man_rts_q  <= 1'b0;
            auto_rts_q <= 1'b0;
            auto_cts_q <= 1'b0;
        end else begin
            if (fcr_wr) begin
                fcr_en_q   <= cfg_data[0];
                trig_sel_q <= cfg_data[7:6];
            end
            ier_q <= ier_d;
            if (mcr_wr) begin
                man_rts_q  <= cfg_data[1];
                auto_rts_q <= cfg_data[6];
                auto_cts_q <= cfg_data[7];
            end
        end
    end

    // receive side
    ufic_fifo #(.W(BW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap(cap),
        .push(dsr_valid), .push_data(dsr_data), .pop(host_rx_rd),
        .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_last_q <= '0;
            overrun_q <= 1'b0;
            frame_q   <= 1'b0;
        end else begin
            if (host_rx_rd && !rx_empty && !rx_flush) begin
                rx_last_q <= rx_head;
            end
            if (dsr_valid && rx_full && !rx_flush) begin
                overrun_q <= 1'b1;
            end else if (ls_rd) begin
                overrun_q <= 1'b0;
            end
            if (dsr_valid && dsr_frame_err) begin
                frame_q <= 1'b1;
            end else if (ls_rd) begin
                frame_q <= 1'b0;
            end
        end
    end

    // transmit side
    ufic_fifo #(.W(BW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap(cap),
        .push(host_tx_wr), .push_data(host_tx_data), .pop(tx_pop),
        .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    ufic_tx_fsm u_tx_fsm (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .have_data(!tx_empty),
        .cts_block(auto_cts_q && cts_n), .ser_ready(ser_ready),
        .ser_valid(ser_valid), .pop(tx_pop)
    );

    always_comb begin
        tx_push_ok = host_tx_wr && !tx_full && !tx_flush;
        thre_evt   = (tx_pop && (tx_count == CW'(1)) && !tx_push_ok)
                   || (tx_flush && !tx_empty)
                   || (ier_wr && cfg_data[1] && !ier_q[1] && tx_empty && !host_tx_wr);
        line_err   = overrun_q || frame_q;
        rx_at_trig = (rx_count >= trig);
    end

    ufic_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ien(ier_q), .thre_en_nxt(ier_d[1]),
        .line_err(line_err), .rx_at_trig(rx_at_trig), .thre_evt(thre_evt),
        .wr_clr(host_tx_wr), .id_rd(id_rd), .id_code(id_code), .irq(irq)
    );

    always_comb begin
        host_rx_data = rx_last_q;
        ser_data     = tx_head;
        id_val       = {fcr_en_q, fcr_en_q, 2'b00, id_code, !irq};
        ls_val       = {1'b0, tx_empty && !ser_busy && !ser_valid, tx_empty,
                        1'b0, frame_q, 1'b0, overrun_q, !rx_empty};
        rts_n        = auto_rts_q ? rx_at_trig : !man_rts_q;
    end

    // R3: a byte arriving at a full receive queue raises overrun
    p_overrun_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr_valid && rx_full && !rx_flush) |=> ls_val[1]);

    // R12: the offered byte does not change before acceptance
    p_ser_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_ready && !tx_flush) |=> $stable(ser_data));

    // R10: an empty receive queue always grants the far end
    p_rts_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_q && rx_empty) |-> !rts_n);

endmodule

// File: tb/uart_fifo_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic       host_tx_wr = 1'b0;
    logic [7:0] host_tx_data = 8'd0;
    logic       host_rx_rd = 1'b0;
    logic [7:0] host_rx_data;
    logic       id_rd = 1'b0;
    logic [7:0] id_val;
    logic       ls_rd = 1'b0;
    logic [7:0] ls_val;
    logic       dsr_valid = 1'b0;
    logic [7:0] dsr_data = 8'd0;
    logic       dsr_frame_err = 1'b0;
    logic       ser_valid;
    logic [7:0] ser_data;
    logic       ser_ready = 1'b0;
    logic       ser_busy = 1'b0;
    logic       cts_n = 1'b0;
    logic       rts_n;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    // bench model of the receive side
    logic [7:0] rxq[$];
    logic [7:0] last_m = 8'd0;
    bit   en_m  = 1'b0;
    int   cap_m = 1;
    int   trig_m = 1;
    bit   ovr_m = 1'b0;
    bit   frm_m = 1'b0;
    logic [2:0] ier_m = 3'd0;

    always #2.5 clk = ~clk;

    uart_fifo_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .id_rd(id_rd), .id_val(id_val), .ls_rd(ls_rd), .ls_val(ls_val),
        .dsr_valid(dsr_valid), .dsr_data(dsr_data), .dsr_frame_err(dsr_frame_err),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
        .ser_busy(ser_busy), .cts_n(cts_n), .rts_n(rts_n), .irq(irq)
    );

    function automatic int lvl_of(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    // expected identification byte for the receive-only scenarios
    function automatic logic [7:0] exp_id();
        logic [2:0] code;
        if (ier_m[2] && (ovr_m || frm_m)) code = 3'd3;
        else if (ier_m[0] && (rxq.size() >= trig_m)) code = 3'd2;
        else code = 3'd0;
        return {en_m, en_m, 2'b00, code, code == 3'd0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
        step();
        cfg_wr = 1'b0;
        if (sel == 2'd0) begin
            if (d[1] || (d[0] != en_m)) rxq.delete();
            en_m   = d[0];
            cap_m  = en_m ? 16 : 1;
            trig_m = en_m ? lvl_of(d[7:6]) : 1;
        end else if (sel == 2'd1) begin
            ier_m = d[2:0];
        end
    endtask

    task automatic push_rx(input logic [7:0] b, input bit fe);
        dsr_valid = 1'b1; dsr_data = b; dsr_frame_err = fe;
        step();
        dsr_valid = 1'b0; dsr_frame_err = 1'b0;
        if (rxq.size() < cap_m) rxq.push_back(b);
        else ovr_m = 1'b1;
        if (fe) frm_m = 1'b1;
    endtask

    task automatic read_rx();
        host_rx_rd = 1'b1;
        step();
        host_rx_rd = 1'b0;
        if (rxq.size() > 0) last_m = rxq.pop_front();
    endtask

    task automatic ls_read();
        ls_rd = 1'b1;
        step();
        ls_rd = 1'b0;
        ovr_m = 1'b0; frm_m = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] b);
        host_tx_wr = 1'b1; host_tx_data = b;
        step();
        host_tx_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin : main
        logic [7:0] got[$];
        int seed_dummy;
        seed_dummy = $urandom(32'd7731);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset values
        chk("R1 ls_val", ls_val, 8'h60);
        chk("R1 id_val", id_val, 8'h01);
        chk("R1 irq", irq, 0);
        chk("R1 rts_n", rts_n, 1);
        chk("R1 ser_valid", ser_valid, 0);

        // R7 enable bits in the identification byte
        cfg(2'd0, 8'h01);
        chk("R7 id with queues on", id_val, 8'hC1);

        // R4 read of an empty queue keeps the last value
        read_rx();
        chk("R4 empty read after reset", host_rx_data, 8'h00);

        // R6 each trigger level
        cfg(2'd1, 8'h01);
        for (int c = 0; c < 4; c++) begin
            cfg(2'd0, {c[1:0], 6'b000011});
            for (int n = 1; n <= lvl_of(c[1:0]); n++) begin
                push_rx(8'(n + 16 * c), 1'b0);
                chk("R6 trigger report", id_val, exp_id());
            end
            chk("R6 irq at level", irq, 1);
        end

        // R10 automatic and manual request to send
        cfg(2'd0, 8'h43);
        cfg(2'd2, 8'h40);
        for (int n = 0; n < 3; n++) push_rx(8'hA0 + 8'(n), 1'b0);
        chk("R10 below trigger", rts_n, 0);
        push_rx(8'hA3, 1'b0);
        chk("R10 at trigger", rts_n, 1);
        read_rx();
        chk("R10 after read", rts_n, 0);
        chk("R2 first out", host_rx_data, 8'hA0);
        cfg(2'd2, 8'h02);
        chk("R10 manual on", rts_n, 0);
        cfg(2'd2, 8'h00);
        chk("R10 manual off", rts_n, 1);

        // R3 framing error flag and line status interrupt
        cfg(2'd1, 8'h05);
        push_rx(8'h33, 1'b1);
        chk("R3 frame flag", ls_val[3], 1);
        chk("R7 line status priority", id_val, exp_id());
        ls_read();
        chk("R3 flag cleared", ls_val[3], 0);

        // R5 flush bits do not persist; disabled queue holds one byte
        cfg(2'd0, 8'h03);
        chk("R5 rx flushed", ls_val[0], 0);
        push_rx(8'h44, 1'b0);
        cfg(2'd0, 8'h01);
        chk("R5 no repeat flush", ls_val[0], 1);
        cfg(2'd0, 8'h00);
        chk("R5 disable flushes", ls_val[0], 0);
        push_rx(8'h51, 1'b0);
        push_rx(8'h52, 1'b0);
        chk("R5 one-byte overrun", ls_val[1], 1);
        read_rx();
        chk("R5 one-byte content", host_rx_data, 8'h51);
        chk("R5 one-byte empty", ls_val[0], 0);
        ls_read();

        // R2 R3 R4 random receive traffic against the model
        cfg(2'd0, 8'h83);
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 50) push_rx(8'($urandom), 1'b0);
            else if (r < 88) read_rx();
            else ls_read();
            chk("R2 R4 read data", host_rx_data, last_m);
            chk("R9 data ready", ls_val[0], rxq.size() > 0);
            chk("R3 overrun flag", ls_val[1], ovr_m);
            chk("R6 R7 identification", id_val, exp_id());
        end

        // transmit path
        cfg(2'd0, 8'h07);
        ls_read();
        cfg(2'd1, 8'h02);
        chk("R8 set on enable while empty", id_val, 8'hC2);
        tx_write(8'h10);
        chk("R8 cleared by write", id_val, 8'hC1);
        for (int n = 1; n < 17; n++) tx_write(8'h10 + 8'(n));
        chk("R9 tx not empty", ls_val[5], 0);
        chk("R12 offer up", ser_valid, 1);
        chk("R12 offer data", ser_data, 8'h10);
        step();
        chk("R12 offer held", ser_data, 8'h10);
        ser_ready = 1'b1;
        for (int k = 0; k < 80; k++) begin
            if (ser_valid) got.push_back(ser_data);
            step();
        end
        ser_ready = 1'b0;
        chk("R3 tx overflow dropped", got.size(), 16);
        for (int k = 0; k < got.size() && k < 16; k++)
            chk("R2 tx order", got[k], 8'h10 + 8'(k));
        chk("R8 set on drain", id_val, 8'hC2);
        chk("R9 idle status", ls_val, 8'h60);
        ser_busy = 1'b1;
        step();
        chk("R9 busy shifter", ls_val[6:5], 2'b01);
        ser_busy = 1'b0;
        id_rd = 1'b1;
        step();
        id_rd = 1'b0;
        chk("R8 cleared by id read", id_val, 8'hC1);

        // R11 automatic clear-to-send gating
        cfg(2'd2, 8'h80);
        cts_n = 1'b1;
        tx_write(8'h5A);
        repeat (3) step();
        chk("R11 held off", ser_valid, 0);
        cts_n = 1'b0;
        step();
        chk("R11 released", ser_valid, 1);
        cts_n = 1'b1;
        step();
        chk("R11 in flight kept", ser_valid, 1);
        chk("R11 in flight data", ser_data, 8'h5A);
        ser_ready = 1'b1;
        step();
        ser_ready = 1'b0;
        chk("R11 accepted", ser_valid, 0);
        chk("R9 empty after accept", ls_val[5], 1);

        summary();
        $finish;
    end

endmodule